// File: doc/BRIEF.md
# Accumulator Processor Core with Step-Counter Control

This block is a small stored-program processor. It has one 16-bit accumulator, a one-bit extension flag E, and a 4096-word memory inside the block. Control is hardwired. A 4-bit step counter is decoded into timing states, and each state is qualified by the decoded opcode, the indirect bit and the interrupt-cycle flag. Together these decide which register drives a shared internal bus and which registers load from it. Every instruction begins with the same three fetch steps. After that comes an optional pointer read, then the execute steps, and finally the step counter is cleared.

The memory is loaded through a side port while reset is held. When reset is released, the core runs from address 0 until it executes a halt.

Character input and output go through two 8-bit ports, each with a flag:
- Input: a strobe captures a byte and marks the input full.
- Output: an acknowledge marks the output ready for the next byte.

If interrupts are enabled and either flag is raised, the core inserts a hardware cycle between instructions. That cycle saves the program counter at address 0 and continues at address 1.

Top module: `acc16_core`

## Requirements
- R1: While reset is low: pc=0, acc=0, e_flag=0, running=1, int_en=0, out_ready=1, in_full=0. While reset is low, ld_we writes ld_data to memory at ld_addr. ld_q always shows the word at ld_addr.
- R2: An instruction word has the indirect bit in bit 15, the opcode in bits 14..12 and the address in bits 11..0. Each fetch adds 1 to pc. The step counter never goes above 6.
- R3: Opcode 0 ANDs the memory word into acc. Opcode 1 adds it into acc and puts the carry-out into E. Opcode 2 loads acc from it. When bit 15 is 1, the address field points to a word that holds the operand's address.
- R4: Opcode 3 stores acc at the effective address. Opcode 4 continues execution at the effective address.
- R5: Opcode 5 stores the return address (the address after the instruction) at the effective address. Execution then continues at the effective address plus 1.
- R6: Opcode 6 increments the memory word at the effective address. If the result is zero, the next instruction is skipped.
- R7: Words 0x7xxx with exactly one of these bits set are register operations: 0x800 clear acc, 0x400 clear E, 0x200 invert acc, 0x100 invert E, 0x080 rotate {acc,E} right, 0x040 rotate {acc,E} left, 0x020 add 1 to acc.
- R8: Register skips add 1 to pc: 0x010 if acc bit 15 is 0, 0x008 if acc bit 15 is 1, 0x004 if acc is 0, 0x002 if E is 0.
- R9: Register operation 0x001 clears running. While halted, pc and acc do not change.
- R10: Words 0xFxxx are I/O operations. 0x800 copies the input byte into acc[7:0], leaves acc[15:8] unchanged and clears in_full. 0x400 copies acc[7:0] to out_char and clears out_ready. 0x200 skips if in_full is 1. 0x100 skips if out_ready is 1.
- R11: I/O 0x080 sets int_en and 0x040 clears it. The interrupt cycle runs once the instruction in progress has finished, if int_en is 1 and in_full or out_ready is 1 during its later steps. It stores pc at address 0, continues at address 1 and clears int_en.
- R12: A pulse on in_strobe captures in_char and sets in_full on the next edge. A pulse on out_ack sets out_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; also enables memory loading |
| ld_we | input | 1 | Memory load write enable (only while in reset) |
| ld_addr | input | 12 | Load/inspect address |
| ld_data | input | 16 | Load data |
| ld_q | output | 16 | Memory word at ld_addr |
| in_strobe | input | 1 | Input byte valid pulse |
| in_char | input | 8 | Input byte |
| in_full | output | 1 | Input flag |
| out_ack | input | 1 | Output consumed pulse |
| out_char | output | 8 | Output byte register |
| out_ready | output | 1 | Output flag |
| running | output | 1 | Run flag |
| int_en | output | 1 | Interrupt enable |
| e_flag | output | 1 | Extension/carry flag |
| pc | output | 12 | Program counter |
| acc | output | 16 | Accumulator |

## Verification
The bench drives rotates with both values of E and an add that overflows exactly to zero. A wrong carry or rotate path shows up as a wrong E or a wrong end bit. Each skip is tested in its taken and not-taken form, and the halt address tells which happened, so an inverted condition ends one word off. The bench also runs a pointer-based load, add and branch, a return from a subroutine through its saved address, and an increment that wraps to zero. A design that ignored the indirect bit or the zero test would load the pointer itself or fail to skip. Finally, an interrupt is raised just after it has been enabled. The saved address and the second increment of acc show that the cycle waited until the following instruction had finished. An enable-then-disable sequence with no flag raised must leave address 0 untouched.

// File: rtl/acc16_core.sv
module acc16_core #(
  parameter int AW = 12,
  parameter int DW = 16,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  output logic [DW-1:0] ld_q,
  input  logic          in_strobe,
  input  logic [CW-1:0] in_char,
  output logic          in_full,
  input  logic          out_ack,
  output logic [CW-1:0] out_char,
  output logic          out_ready,
  output logic          running,
  output logic          int_en,
  output logic          e_flag,
  output logic [AW-1:0] pc,
  output logic [DW-1:0] acc
);
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] A1 = AW'(1);
  localparam logic [DW-1:0] D1 = DW'(1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] ar_q, pc_q;
  logic [DW-1:0] dr_q, ac_q, ir_q, tr_q, bus, mem_rd;
  logic [CW-1:0] inpr_q, outr_q;
  logic [3:0]    sc_q;
  logic [2:0]    bsel;
  logic          i_q, s_q, e_q, r_q, ien_q, fgi_q, fgo_q;
  logic [6:0]    t;
  logic [7:0]    d;
  logic [11:0]   b;
  logic          nr, rr, pio, skip, mem_we, clr_sc, rd_op;
  logic [DW:0]   sum;

  assign t      = s_q ? (7'd1 << sc_q) : 7'd0;
  assign d      = 8'd1 << ir_q[DW-2:DW-4];
  assign b      = ir_q[11:0];
  assign nr     = ~r_q;
  assign rr     = d[7] & ~i_q & t[3];
  assign pio    = d[7] & i_q & t[3];
  assign rd_op  = d[0] | d[1] | d[2] | d[6];
  assign sum    = {1'b0, ac_q} + {1'b0, dr_q};
  assign mem_rd = mem[ar_q];
  assign ld_q   = mem[ld_addr];

  always_comb begin
    if (t[0])                           bsel = 3'd2;
    else if (nr & t[1])                 bsel = 3'd7;
    else if (r_q & t[1])                bsel = 3'd6;
    else if (nr & t[2])                 bsel = 3'd5;
    else if (~d[7] & i_q & t[3])        bsel = 3'd7;
    else if (t[4] & rd_op)              bsel = 3'd7;
    else if (t[4] & d[3])               bsel = 3'd4;
    else if ((t[4] & d[4]) | (t[5] & d[5])) bsel = 3'd1;
    else if (t[4] & d[5])               bsel = 3'd2;
    else if ((t[5] & d[2]) | (t[6] & d[6])) bsel = 3'd3;
    else if (pio & b[10])               bsel = 3'd4;
    else                                bsel = 3'd0;
  end

  always_comb begin
    case (bsel)
      3'd1:    bus = {{(DW-AW){1'b0}}, ar_q};
      3'd2:    bus = {{(DW-AW){1'b0}}, pc_q};
      3'd3:    bus = dr_q;
      3'd4:    bus = ac_q;
      3'd5:    bus = ir_q;
      3'd6:    bus = tr_q;
      3'd7:    bus = mem_rd;
      default: bus = '0;
    endcase
  end

  assign mem_we = (r_q & t[1]) | (t[4] & (d[3] | d[5])) | (d[6] & t[6]);
  assign clr_sc = (r_q & t[2]) | (t[5] & (d[0] | d[1] | d[2] | d[5])) |
                  (t[4] & (d[3] | d[4])) | (d[6] & t[6]) | rr | pio;
  assign skip   = (rr & ((b[4] & ~ac_q[DW-1]) | (b[3] & ac_q[DW-1]) |
                         (b[2] & (ac_q == '0)) | (b[1] & ~e_q))) |
                  (pio & ((b[9] & fgi_q) | (b[8] & fgo_q))) |
                  (d[6] & t[6] & (dr_q == '0));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      if (ld_we) mem[ld_addr] <= ld_data;
    end else if (mem_we) begin
      mem[ar_q] <= bus;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sc_q <= '0; s_q <= 1'b1; r_q <= 1'b0; ien_q <= 1'b0;
      pc_q <= '0; ar_q <= '0; ir_q <= '0; dr_q <= '0; tr_q <= '0;
      ac_q <= '0; e_q <= 1'b0; i_q <= 1'b0;
      inpr_q <= '0; outr_q <= '0; fgi_q <= 1'b0; fgo_q <= 1'b1;
    end else begin
      if (clr_sc) sc_q <= '0;
      else if (s_q) sc_q <= sc_q + 4'd1;

      if (s_q & ~(t[0] | t[1] | t[2]) & ien_q & (fgi_q | fgo_q)) r_q <= 1'b1;
      else if (r_q & t[2]) r_q <= 1'b0;

      if (nr & t[0])                  ar_q <= bus[AW-1:0];
      else if (r_q & t[0])            ar_q <= '0;
      else if (nr & t[2])             ar_q <= bus[AW-1:0];
      else if (~d[7] & i_q & t[3])    ar_q <= bus[AW-1:0];
      else if (d[5] & t[4])           ar_q <= ar_q + A1;

      if (r_q & t[1])                 pc_q <= '0;
      else if ((d[4] & t[4]) | (d[5] & t[5])) pc_q <= bus[AW-1:0];
      else if ((nr & t[1]) | (r_q & t[2]) | skip) pc_q <= pc_q + A1;

      if (nr & t[1]) ir_q <= bus;
      if (nr & t[2]) i_q  <= ir_q[DW-1];
      if (r_q & t[0]) tr_q <= bus;

      if (t[4] & rd_op)     dr_q <= bus;
      else if (d[6] & t[5]) dr_q <= dr_q + D1;

      if (d[0] & t[5])      ac_q <= ac_q & dr_q;
      else if (d[1] & t[5]) {e_q, ac_q} <= sum;
      else if (d[2] & t[5]) ac_q <= bus;
      else if (rr) begin
        if (b[11])      ac_q <= '0;
        else if (b[10]) e_q  <= 1'b0;
        else if (b[9])  ac_q <= ~ac_q;
        else if (b[8])  e_q  <= ~e_q;
        else if (b[7])  begin ac_q <= {e_q, ac_q[DW-1:1]}; e_q <= ac_q[0]; end
        else if (b[6])  begin ac_q <= {ac_q[DW-2:0], e_q}; e_q <= ac_q[DW-1]; end
        else if (b[5])  ac_q <= ac_q + D1;
        if (b[0]) s_q <= 1'b0;
      end else if (pio & b[11]) ac_q[CW-1:0] <= inpr_q;

      if (pio & b[10]) begin outr_q <= bus[CW-1:0]; fgo_q <= 1'b0; end
      else if (out_ack) fgo_q <= 1'b1;

      if (in_strobe) begin inpr_q <= in_char; fgi_q <= 1'b1; end
      else if (pio & b[11]) fgi_q <= 1'b0;

      if (pio & b[7])                    ien_q <= 1'b1;
      else if ((pio & b[6]) | (r_q & t[2])) ien_q <= 1'b0;
    end
  end

  assign in_full   = fgi_q;
  assign out_char  = outr_q;
  assign out_ready = fgo_q;
  assign running   = s_q;
  assign int_en    = ien_q;
  assign e_flag    = e_q;
  assign pc        = pc_q;
  assign acc       = ac_q;
endmodule

module acc16_core_chk #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_q,
  input logic          r_q,
  input logic          ien_q,
  input logic          fgi_q,
  input logic          in_strobe,
  input logic [3:0]    sc_q,
  input logic [AW-1:0] pc_q,
  input logic [DW-1:0] ac_q
);
  a_r2_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    sc_q <= 4'd6);
  a_r2_fetch_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (s_q && !r_q && sc_q == 4'd1) |=> (pc_q == $past(pc_q) + AW'(1)));
  a_r9_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !s_q |=> ($stable(pc_q) && $stable(ac_q) && !s_q));
  a_r11_int_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (s_q && r_q && sc_q == 4'd2) |=> (pc_q == AW'(1) && !ien_q && !r_q && sc_q == 4'd0));
  a_r11_int_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_q) |-> $past(ien_q));
  a_r12_in_flag: assert property (@(posedge clk) disable iff (!rst_n)
    in_strobe |=> fgi_q);
endmodule

bind acc16_core acc16_core_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .s_q(s_q), .r_q(r_q), .ien_q(ien_q), .fgi_q(fgi_q),
  .in_strobe(in_strobe), .sc_q(sc_q), .pc_q(pc_q), .ac_q(ac_q)
);

// File: tb/acc16_core_tb_top.sv
module acc16_core_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_we = 1'b0;
  logic [11:0] ld_addr = '0;
  logic [15:0] ld_data = '0;
  logic [15:0] ld_q;
  logic        in_strobe = 1'b0;
  logic [7:0]  in_char = '0;
  logic        in_full;
  logic        out_ack = 1'b0;
  logic [7:0]  out_char;
  logic        out_ready, running, int_en, e_flag;
  logic [11:0] pc;
  logic [15:0] acc;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  acc16_core dut_i (
    .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data),
    .ld_q(ld_q), .in_strobe(in_strobe), .in_char(in_char), .in_full(in_full),
    .out_ack(out_ack), .out_char(out_char), .out_ready(out_ready), .running(running),
    .int_en(int_en), .e_flag(e_flag), .pc(pc), .acc(acc)
  );

  // op, operand, E in, expected acc, expected E, expected halt pc
  localparam logic [61:0] TBL [0:18] = '{
    {16'h7800, 16'h1234, 1'b0, 16'h0000, 1'b0, 12'd5},
    {16'h7200, 16'h00FF, 1'b0, 16'hFF00, 1'b0, 12'd5},
    {16'h7100, 16'h5555, 1'b0, 16'h5555, 1'b1, 12'd5},
    {16'h7400, 16'h8000, 1'b1, 16'h8000, 1'b0, 12'd5},
    {16'h7080, 16'h0003, 1'b1, 16'h8001, 1'b1, 12'd5},
    {16'h7040, 16'h8002, 1'b0, 16'h0004, 1'b1, 12'd5},
    {16'h7020, 16'hFFFF, 1'b1, 16'h0000, 1'b1, 12'd5},
    {16'h1101, 16'hFFFF, 1'b0, 16'h0000, 1'b1, 12'd5},
    {16'h1101, 16'h1000, 1'b1, 16'h1001, 1'b0, 12'd5},
    {16'h0101, 16'h00F3, 1'b1, 16'h0001, 1'b1, 12'd5},
    {16'hA102, 16'h7777, 1'b0, 16'h0001, 1'b0, 12'd5},
    {16'h7010, 16'h0005, 1'b0, 16'h0005, 1'b0, 12'd6},
    {16'h7010, 16'h8000, 1'b0, 16'h8000, 1'b0, 12'd5},
    {16'h7008, 16'h8000, 1'b0, 16'h8000, 1'b0, 12'd6},
    {16'h7004, 16'h0000, 1'b0, 16'h0000, 1'b0, 12'd6},
    {16'h7004, 16'h0001, 1'b0, 16'h0001, 1'b0, 12'd5},
    {16'h7002, 16'h0001, 1'b0, 16'h0001, 1'b0, 12'd6},
    {16'h7002, 16'h0001, 1'b1, 16'h0001, 1'b1, 12'd5},
    {16'h9102, 16'h0010, 1'b0, 16'h0011, 1'b0, 12'd5}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [15:0] v);
    @(negedge clk);
    ld_we = 1'b1; ld_addr = a; ld_data = v;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [15:0] v);
    @(negedge clk);
    ld_addr = a;
    #1 v = ld_q;
  endtask

  task automatic enter_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_to_halt(input string tag);
    int n = 0;
    @(negedge clk);
    rst_n = 1'b1;
    do begin
      @(negedge clk);
      n++;
    end while (running && n < 3000);
    chk(!running, tag, running, 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        bad++; total++;
        $display("FAIL watchdog actual=%0d expected=<150000", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [15:0] m;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pc == 12'd0 && acc == 16'd0 && !e_flag, "R1 regs", {pc, acc[3:0]}, 0);
    chk(running && !int_en && out_ready && !in_full, "R1 flags",
        {running, int_en, out_ready, in_full}, 4'b1010);
    wr(12'h101, 16'h0001);
    wr(12'h102, 16'h0101);
    rd(12'h102, m);
    chk(m == 16'h0101, "R1 load port", m, 16'h0101);

    for (int k = 0; k < 19; k++) begin
      logic [61:0] v = TBL[k];
      string tag;
      if (v[61:58] == 4'h7 && v[57:50] != 8'h00) tag = "R7";
      else if (v[61:58] == 4'h7) tag = "R8";
      else tag = "R3";
      wr(12'h000, 16'h2100);
      wr(12'h001, 16'h7400);
      wr(12'h002, v[29] ? 16'h7100 : 16'h7400);
      wr(12'h003, v[61:46]);
      wr(12'h004, 16'h7001);
      wr(12'h005, 16'h7001);
      wr(12'h100, v[45:30]);
      run_to_halt({tag, " halt"});
      chk(acc == v[28:13], {tag, " acc"}, acc, v[28:13]);
      chk(e_flag == v[12], {tag, " E"}, e_flag, v[12]);
      chk(pc == v[11:0], {tag, " pc/skip (R2)"}, pc, v[11:0]);
      enter_reset();
    end

    // R4 store and branch
    wr(12'h000, 16'h2100); wr(12'h001, 16'h4004); wr(12'h002, 16'h7001);
    wr(12'h004, 16'h3103); wr(12'h005, 16'h7001); wr(12'h100, 16'hBEEF);
    wr(12'h103, 16'h0000);
    run_to_halt("R4 halt");
    chk(pc == 12'd6, "R4 branch pc", pc, 6);
    enter_reset();
    rd(12'h103, m);
    chk(m == 16'hBEEF, "R4 stored word", m, 16'hBEEF);

    // R5 call and return through saved address
    wr(12'h000, 16'h5110); wr(12'h001, 16'h7001); wr(12'h111, 16'hC110);
    run_to_halt("R5 halt");
    chk(pc == 12'd2, "R5 return pc", pc, 2);
    enter_reset();
    rd(12'h110, m);
    chk(m == 16'h0001, "R5 saved addr", m, 1);

    // R6 increment and skip
    wr(12'h000, 16'h6120); wr(12'h001, 16'h7001); wr(12'h002, 16'h7001);
    wr(12'h120, 16'hFFFF);
    run_to_halt("R6 halt");
    chk(pc == 12'd3, "R6 skip on zero", pc, 3);
    enter_reset();
    rd(12'h120, m);
    chk(m == 16'h0000, "R6 wrapped word", m, 0);
    wr(12'h120, 16'h0005);
    run_to_halt("R6 halt b");
    chk(pc == 12'd2, "R6 no skip", pc, 2);
    enter_reset();
    rd(12'h120, m);
    chk(m == 16'h0006, "R6 incremented", m, 6);

    // R10 / R12 character input and output
    wr(12'h000, 16'h2100); wr(12'h001, 16'hF200); wr(12'h002, 16'h4001);
    wr(12'h003, 16'hF800); wr(12'h004, 16'hF400); wr(12'h005, 16'h7001);
    wr(12'h100, 16'h1200);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    chk(running && !in_full, "R10 polls while empty", {running, in_full}, 2'b10);
    in_strobe = 1'b1; in_char = 8'h5A;
    @(negedge clk);
    in_strobe = 1'b0;
    chk(in_full, "R12 strobe sets flag", in_full, 1);
    begin
      int n = 0;
      while (running && n < 3000) begin @(negedge clk); n++; end
    end
    chk(!running, "R10 halt", running, 0);
    chk(acc == 16'h125A, "R10 input byte", acc, 16'h125A);
    chk(!in_full, "R10 input flag cleared", in_full, 0);
    chk(out_char == 8'h5A && !out_ready, "R10 output byte", {out_char, out_ready}, 9'h0B4);
    out_ack = 1'b1;
    @(negedge clk);
    out_ack = 1'b0;
    chk(out_ready, "R12 ack sets ready", out_ready, 1);
    enter_reset();

    // R11 interrupt after enable
    wr(12'h000, 16'hF080); wr(12'h001, 16'h7020); wr(12'h002, 16'h7001);
    run_to_halt("R11 halt");
    chk(acc == 16'h0002, "R11 isr reran inc", acc, 2);
    chk(pc == 12'd3 && !int_en, "R11 pc/int_en", {pc, int_en}, 13'h006);
    repeat (20) @(negedge clk);
    chk(pc == 12'd3 && acc == 16'h0002, "R9 halted state holds", pc, 3);
    enter_reset();
    rd(12'h000, m);
    chk(m == 16'h0002, "R11 saved pc", m, 2);

    // R11 enable then disable with no flag raised; R10 output-ready skip not taken
    wr(12'h000, 16'hF400); wr(12'h001, 16'hF080); wr(12'h002, 16'hF040);
    wr(12'h003, 16'hF100); wr(12'h004, 16'h7001); wr(12'h005, 16'h7001);
    run_to_halt("R11 halt b");
    chk(pc == 12'd5 && !int_en, "R11 disable / R10 no skip", {pc, int_en}, 13'h00A);
    enter_reset();
    rd(12'h000, m);
    chk(m == 16'hF400, "R11 no interrupt", m, 16'hF400);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule